// File: doc/BRIEF.md
# Paged Memory Write Sequencer

This block sits on the host side of a byte-wide parallel memory with a self-timed internal write cycle. It takes one request (start address, byte count and two mode bits) and a byte stream. It then writes those bytes to the memory as one page-load burst, waits until the memory reports that its internal programming has finished, and signals completion. When the request asks for it, the burst is preceded by the three-write key sequence that lets a write-protected memory accept one page load.

The memory side is a simple master port. It has an address, write data, a one-cycle write strobe and a one-cycle read strobe, and read data returns in the cycle after the read strobe. All intervals are counted in clock cycles and set by parameters. These are the spacing between byte loads, the spacing between status reads, the settling delay after the memory is ready, and the limit on polling. Completion is found either by watching a status bit that flips on every read while the memory is busy, or by watching the top data bit, which reads inverted until programming ends. LOAD_GAP must be at least 2 and POLL_GAP at least 3.

Top module: `pwe_engine`

## Requirements
- R1: After reset the engine is idle: req_ready is high, and src_ready, mem_we, mem_re, done, err_page and err_tmo are low.
- R2: When req_unlock is set, the first three writes are 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. The data bytes follow in stream order, at consecutive addresses starting at req_addr.
- R3: Two consecutive write strobes are never fewer than LOAD_GAP cycles apart. While the byte stream keeps up, they are exactly LOAD_GAP cycles apart.
- R4: A request with req_len of 0, or one whose bytes would run past the end of its 128-byte page (req_addr[6:0] + req_len > 128), gets a one-cycle err_page and causes no bus activity. A request that ends exactly on the page end is accepted.
- R5: With req_datapoll low, the engine reads the last written address and reports ready once two consecutive reads agree in bit 6.
- R6: With req_datapoll high, the engine reads the last written address and reports ready once bit 7 of the read equals bit 7 of the last byte written.
- R7: done is raised no sooner than REC_CYC cycles after the final status read. No write occurs between the first status read and the end of the transaction.
- R8: If ready is not seen within TMO_CYC cycles after polling starts, the engine pulses err_tmo, does not pulse done, and returns to idle.
- R9: req_ready is high only while the engine is idle, and a request is taken only then. The cycle of the done pulse is already idle, so a waiting request is taken in that cycle.
- R10: done, err_page and err_tmo are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken this cycle |
| req_addr | input | 15 | Address of the first data byte |
| req_len | input | 8 | Number of data bytes, 1 to 128 |
| req_unlock | input | 1 | Prefix the three-write key sequence |
| req_datapoll | input | 1 | 1: bit-7 completion check, 0: bit-6 toggle check |
| src_valid | input | 1 | Stream byte present |
| src_data | input | 8 | Stream byte |
| src_ready | output | 1 | Byte consumed this cycle if src_valid |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| done | output | 1 | Transaction finished |
| err_page | output | 1 | Request rejected for length or page crossing |
| err_tmo | output | 1 | Polling limit reached |

## Verification
Two events can land on the same edge: the done pulse of one transaction and the acceptance of the next request. The bench provokes this by asserting a second request while the first is still loading and keeping it asserted. The second request must be taken exactly in the cycle where done is high. The scoreboard must then see the second key sequence and data only after the first transaction's writes, and the done count must rise by two.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_UNLOCK  = 3'd1,
        ST_LOAD    = 3'd2,
        ST_POLL    = 3'd3,
        ST_RECOVER = 3'd4
    } pwe_state_e;

    // key sequence address for each of the three prefix steps
    function automatic logic [ADDR_W-1:0] key_addr(input logic [1:0] step);
        return (step == 2'd1) ? 15'h2AAA : 15'h5555;
    endfunction

    // key sequence data for each of the three prefix steps
    function automatic logic [DATA_W-1:0] key_data(input logic [1:0] step);
        case (step)
            2'd0:    return 8'hAA;
            2'd1:    return 8'h55;
            default: return 8'hA0;
        endcase
    endfunction

endpackage

// File: rtl/pwe_page_chk.sv
module pwe_page_chk #(
    parameter int PAGE_BYTES = 128
) (
    input  logic [$clog2(PAGE_BYTES)-1:0] offset,
    input  logic [$clog2(PAGE_BYTES):0]   len,
    output logic                          fits
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int SUM_W = OFF_W + 2;

    logic [SUM_W-1:0] end_pos;

    // one past the last byte, measured from the start of the page
    assign end_pos = SUM_W'(offset) + SUM_W'(len);
    assign fits    = (len != '0) && (end_pos <= SUM_W'(PAGE_BYTES));
endmodule

// File: rtl/pwe_poll_eval.sv
module pwe_poll_eval (
    input  logic datapoll,
    input  logic rd_bit7,
    input  logic rd_bit6,
    input  logic last_bit7,
    input  logic have_prev,
    input  logic prev_bit6,
    output logic ready
);
    logic tog_ready;
    logic dat_ready;

    assign tog_ready = have_prev && (rd_bit6 == prev_bit6);
    assign dat_ready = (rd_bit7 == last_bit7);
    assign ready     = datapoll ? dat_ready : tog_ready;
endmodule

// File: rtl/pwe_engine.sv
module pwe_engine
    import pwe_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int LOAD_GAP   = 20,
    parameter int POLL_GAP   = 8,
    parameter int REC_CYC    = 1250,
    parameter int TMO_CYC    = 687500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [14:0]       req_addr,
    input  logic [7:0]        req_len,
    input  logic              req_unlock,
    input  logic              req_datapoll,
    input  logic              src_valid,
    input  logic [7:0]        src_data,
    output logic              src_ready,
    output logic [14:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              done,
    output logic              err_page,
    output logic              err_tmo
);
    localparam int OFF_W    = $clog2(PAGE_BYTES);
    localparam int LEN_W    = OFF_W + 1;
    localparam int WAIT_MAX = (REC_CYC > LOAD_GAP) ?
                              ((REC_CYC > POLL_GAP) ? REC_CYC : POLL_GAP) :
                              ((LOAD_GAP > POLL_GAP) ? LOAD_GAP : POLL_GAP);
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam int TMO_W    = $clog2(TMO_CYC + 1);

    typedef struct packed {
        pwe_state_e          st;
        logic [1:0]          step;
        logic [WAIT_W-1:0]   wt;
        logic [TMO_W-1:0]    tmo;
        logic [LEN_W-1:0]    left;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   last_addr;
        logic                last_bit7;
        logic                datapoll;
        logic                have_prev;
        logic                prev_bit6;
        logic                rsamp;
        logic                we;
        logic                re;
        logic [ADDR_W-1:0]   maddr;
        logic [DATA_W-1:0]   mwdata;
        logic                done;
        logic                errp;
        logic                errt;
    } pwe_regs_t;

    pwe_regs_t r_q, r_d;
    logic      page_fits;
    logic      poll_ready;
    logic      unused_rd;

    assign unused_rd = ^mem_rdata[5:0];

    pwe_page_chk #(.PAGE_BYTES(PAGE_BYTES)) i_page_chk (
        .offset (req_addr[OFF_W-1:0]),
        .len    (req_len[LEN_W-1:0]),
        .fits   (page_fits)
    );

    pwe_poll_eval i_poll_eval (
        .datapoll  (r_q.datapoll),
        .rd_bit7   (mem_rdata[7]),
        .rd_bit6   (mem_rdata[6]),
        .last_bit7 (r_q.last_bit7),
        .have_prev (r_q.have_prev),
        .prev_bit6 (r_q.prev_bit6),
        .ready     (poll_ready)
    );

    always_comb begin
        r_d       = r_q;
        r_d.we    = 1'b0;
        r_d.re    = 1'b0;
        r_d.done  = 1'b0;
        r_d.errp  = 1'b0;
        r_d.errt  = 1'b0;
        r_d.rsamp = r_q.re;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!page_fits) begin
                        r_d.errp = 1'b1;
                    end else begin
                        r_d.addr     = req_addr;
                        r_d.left     = req_len[LEN_W-1:0];
                        r_d.datapoll = req_datapoll;
                        r_d.step     = 2'd0;
                        r_d.wt       = '0;
                        r_d.st       = req_unlock ? ST_UNLOCK : ST_LOAD;
                    end
                end
            end
            ST_UNLOCK: begin
                if (r_q.wt != '0) begin
                    r_d.wt = r_q.wt - 1'b1;
                end else begin
                    r_d.we     = 1'b1;
                    r_d.maddr  = key_addr(r_q.step);
                    r_d.mwdata = key_data(r_q.step);
                    r_d.wt     = WAIT_W'(LOAD_GAP - 1);
                    if (r_q.step == 2'd2) r_d.st = ST_LOAD;
                    else                  r_d.step = r_q.step + 2'd1;
                end
            end
            ST_LOAD: begin
                if (r_q.wt != '0) begin
                    r_d.wt = r_q.wt - 1'b1;
                end else if (src_valid) begin
                    r_d.we        = 1'b1;
                    r_d.maddr     = r_q.addr;
                    r_d.mwdata    = src_data;
                    r_d.last_addr = r_q.addr;
                    r_d.last_bit7 = src_data[7];
                    r_d.addr      = r_q.addr + 1'b1;
                    r_d.left      = r_q.left - 1'b1;
                    r_d.wt        = WAIT_W'(LOAD_GAP - 1);
                    if (r_q.left == LEN_W'(1)) begin
                        r_d.st        = ST_POLL;
                        r_d.tmo       = '0;
                        r_d.have_prev = 1'b0;
                    end
                end
            end
            ST_POLL: begin
                r_d.tmo = r_q.tmo + 1'b1;
                if (r_q.rsamp) begin
                    r_d.have_prev = 1'b1;
                    r_d.prev_bit6 = mem_rdata[6];
                end
                if (r_q.rsamp && poll_ready) begin
                    r_d.st = ST_RECOVER;
                    r_d.wt = WAIT_W'(REC_CYC - 1);
                end else if (r_q.tmo == TMO_W'(TMO_CYC - 1)) begin
                    r_d.errt = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (r_q.wt != '0) begin
                    r_d.wt = r_q.wt - 1'b1;
                end else if (!r_q.re && !r_q.rsamp) begin
                    r_d.re    = 1'b1;
                    r_d.maddr = r_q.last_addr;
                    r_d.wt    = WAIT_W'(POLL_GAP - 1);
                end
            end
            ST_RECOVER: begin
                if (r_q.wt != '0) begin
                    r_d.wt = r_q.wt - 1'b1;
                end else begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign src_ready = (r_q.st == ST_LOAD) && (r_q.wt == '0);
    assign mem_addr  = r_q.maddr;
    assign mem_wdata = r_q.mwdata;
    assign mem_we    = r_q.we;
    assign mem_re    = r_q.re;
    assign done      = r_q.done;
    assign err_page  = r_q.errp;
    assign err_tmo   = r_q.errt;
endmodule

// File: rtl/pwe_engine_chk.sv
module pwe_engine_chk #(
    parameter int LOAD_GAP = 20,
    parameter int REC_CYC  = 1250
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic mem_we,
    input logic mem_re,
    input logic done,
    input logic err_page,
    input logic err_tmo
);
    localparam int GW = $clog2(LOAD_GAP + 1);
    localparam int RW = $clog2(REC_CYC + 1);

    logic [GW-1:0] since_we;
    logic [RW-1:0] since_re;
    logic          seen_we;
    logic          polled;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_we <= '0;
            since_re <= '0;
            seen_we  <= 1'b0;
            polled   <= 1'b0;
        end else begin
            if (mem_we)                        since_we <= GW'(1);
            else if (since_we < GW'(LOAD_GAP)) since_we <= since_we + 1'b1;
            if (mem_re)                        since_re <= RW'(1);
            else if (since_re < RW'(REC_CYC))  since_re <= since_re + 1'b1;
            seen_we <= seen_we | mem_we;
            if (mem_re)               polled <= 1'b1;
            else if (done || err_tmo) polled <= 1'b0;
        end
    end

    AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && seen_we) |-> (since_we >= GW'(LOAD_GAP))); // R3
    AST_NO_WRITE_IN_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !polled); // R7
    AST_RECOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_re >= RW'(REC_CYC))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_TMO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |=> !err_tmo); // R10
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_page, err_tmo})); // R10
    AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready || err_page)); // R9
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_page |-> (!mem_we && !mem_re)); // R4
endmodule

bind pwe_engine pwe_engine_chk #(
    .LOAD_GAP (LOAD_GAP),
    .REC_CYC  (REC_CYC)
) i_pwe_engine_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .done      (done),
    .err_page  (err_page),
    .err_tmo   (err_tmo)
);

// File: tb/test_pwe_engine.sv
module test_pwe_engine;
    localparam int LOAD_GAP = 20;
    localparam int POLL_GAP = 8;
    localparam int REC_CYC  = 1250;
    localparam int TMO_CYC  = 3000;
    localparam int BUSY     = 400;

    typedef struct {
        logic [14:0] a;
        logic [7:0]  d;
        string       tag;
    } wr_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_ready, req_unlock, req_datapoll;
    logic [14:0] req_addr;
    logic [7:0]  req_len;
    logic        src_valid = 1'b0, src_ready;
    logic [7:0]  src_data = 8'h00;
    logic [14:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = 8'h00;
    logic        mem_we, mem_re, done, err_page, err_tmo;

    always #4 clk = ~clk;

    pwe_engine #(
        .PAGE_BYTES (128),
        .LOAD_GAP   (LOAD_GAP),
        .POLL_GAP   (POLL_GAP),
        .REC_CYC    (REC_CYC),
        .TMO_CYC    (TMO_CYC)
    ) i_pwe_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_unlock   (req_unlock),
        .req_datapoll (req_datapoll),
        .src_valid    (src_valid),
        .src_data     (src_data),
        .src_ready    (src_ready),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_we       (mem_we),
        .mem_re       (mem_re),
        .mem_rdata    (mem_rdata),
        .done         (done),
        .err_page     (err_page),
        .err_tmo      (err_tmo)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int done_cnt = 0, errp_cnt = 0, errt_cnt = 0, we_total = 0;
    int last_we_cyc = 0, last_re_cyc = 0;
    bit have_we = 0, prev_done = 0, prev_errp = 0, prev_errt = 0;
    logic [14:0] last_we_addr = '0;
    wr_t         exp_q[$];
    logic [7:0]  src_q[$];
    bit          src_fire = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) cyc++;

    // memory model: busy after each write; status reads while busy
    int          busy_left = 0;
    bit          stuck = 0;
    bit          tog = 0;
    logic [7:0]  lastw = 8'h00;
    logic [7:0]  mem_m[int];
    always @(posedge clk) begin
        if (mem_we) begin
            mem_m[int'(mem_addr)] = mem_wdata;
            lastw = mem_wdata;
            busy_left = BUSY;
        end else if (busy_left > 0) begin
            busy_left--;
        end
        if (mem_re) begin
            if (busy_left > 0 || stuck) begin
                mem_rdata <= {~lastw[7], tog, lastw[5:0]};
                tog = ~tog;
            end else begin
                mem_rdata <= mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'hFF;
            end
        end
    end

    // byte source
    always @(negedge clk) begin
        if (src_fire) void'(src_q.pop_front());
        src_valid = (src_q.size() > 0);
        src_data  = src_valid ? src_q[0] : 8'h00;
        src_fire  = src_valid && src_ready;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                we_total++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected write", longint'({mem_addr, mem_wdata}), 0);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.a && mem_wdata == e.d, e.tag, "write addr/data",
                          longint'({mem_addr, mem_wdata}), longint'({e.a, e.d}));
                end
                if (have_we && (cyc - last_we_cyc) < 1000)
                    check((cyc - last_we_cyc) == LOAD_GAP, "R3", "load spacing",
                          cyc - last_we_cyc, LOAD_GAP);
                have_we = 1;
                last_we_cyc = cyc;
                last_we_addr = mem_addr;
            end
            if (mem_re) begin
                check(mem_addr == last_we_addr, "R5", "poll address", mem_addr, last_we_addr);
                last_re_cyc = cyc;
            end
            if (done) begin
                done_cnt++;
                check(!prev_done, "R10", "done longer than one cycle", 1, 0);
                check((cyc - last_re_cyc) >= REC_CYC, "R7", "recovery cycles",
                      cyc - last_re_cyc, REC_CYC);
                check((cyc - last_we_cyc) >= BUSY + REC_CYC, "R5 R6", "done before memory ready",
                      cyc - last_we_cyc, BUSY + REC_CYC);
            end
            if (err_page) begin
                errp_cnt++;
                check(!prev_errp, "R10", "err_page longer than one cycle", 1, 0);
            end
            if (err_tmo) begin
                errt_cnt++;
                check(!prev_errt, "R10", "err_tmo longer than one cycle", 1, 0);
            end
            prev_done = done;
            prev_errp = err_page;
            prev_errt = err_tmo;
        end
    end

    task automatic send_req(input logic [14:0] a, input int len, input bit unl, input bit dp,
                            input int seed, input bit ok, output bit in_done);
        if (ok) begin
            if (unl) begin
                exp_q.push_back('{15'h5555, 8'hAA, "R2"});
                exp_q.push_back('{15'h2AAA, 8'h55, "R2"});
                exp_q.push_back('{15'h5555, 8'hA0, "R2"});
            end
            for (int i = 0; i < len; i++) begin
                logic [7:0] d;
                d = 8'(seed * 29 + i * 13 + (i >> 2));
                exp_q.push_back('{a + 15'(i), d, "R2"});
                src_q.push_back(d);
            end
        end
        @(negedge clk);
        req_valid    = 1'b1;
        req_addr     = a;
        req_len      = 8'(len);
        req_unlock   = unl;
        req_datapoll = dp;
        while (!req_ready) @(negedge clk);
        in_done = done;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_events(input int target);
        while (done_cnt + errp_cnt + errt_cnt < target) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        finish_run();
    end

    initial begin
        bit ind, ind2;
        int base, d0, wt0;
        req_valid = 0; req_addr = '0; req_len = '0; req_unlock = 0; req_datapoll = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(src_ready == 1'b0, "R1", "src_ready after reset", src_ready, 0);
        check(!mem_we && !mem_re, "R1", "strobes after reset", {mem_we, mem_re}, 0);
        check(!done && !err_page && !err_tmo, "R1", "pulses after reset",
              {done, err_page, err_tmo}, 0);

        // R2 R5: keyed, toggle polling
        base = done_cnt + errp_cnt + errt_cnt; d0 = done_cnt;
        send_req(15'h0100, 16, 1, 0, 3, 1, ind);
        wait_events(base + 1);
        check(done_cnt == d0 + 1, "R5", "toggle-polled done", done_cnt, d0 + 1);
        check(exp_q.size() == 0, "R2", "writes outstanding", exp_q.size(), 0);

        // R6: data polling, offset start, no key
        base = done_cnt + errp_cnt + errt_cnt; d0 = done_cnt;
        send_req(15'h0203, 5, 0, 1, 7, 1, ind);
        wait_events(base + 1);
        check(done_cnt == d0 + 1, "R6", "data-polled done", done_cnt, d0 + 1);
        check(exp_q.size() == 0, "R2", "writes outstanding", exp_q.size(), 0);

        // R4: page crossing and zero length rejected
        base = errp_cnt; wt0 = we_total; d0 = done_cnt;
        send_req(15'h0350, 64, 0, 0, 0, 0, ind);
        repeat (3) @(negedge clk);
        check(errp_cnt == base + 1, "R4", "crossing reject", errp_cnt, base + 1);
        send_req(15'h0300, 0, 1, 0, 0, 0, ind);
        repeat (3) @(negedge clk);
        check(errp_cnt == base + 2, "R4", "zero length reject", errp_cnt, base + 2);
        send_req(15'h0102, 127, 0, 0, 0, 0, ind);
        repeat (60) @(negedge clk);
        check(errp_cnt == base + 3, "R4", "one past page end", errp_cnt, base + 3);
        check(we_total == wt0 && !mem_re, "R4", "bus quiet after reject", we_total, wt0);
        check(done_cnt == d0 && req_ready, "R4", "engine idle after reject", done_cnt, d0);

        // R4 R3: exactly one full page, keyed
        base = done_cnt + errp_cnt + errt_cnt; d0 = done_cnt;
        send_req(15'h0400, 128, 1, 0, 11, 1, ind);
        wait_events(base + 1);
        check(done_cnt == d0 + 1, "R4", "full page accepted", done_cnt, d0 + 1);
        check(exp_q.size() == 0, "R3", "full page writes", exp_q.size(), 0);

        // R9: second request waiting while the first runs
        base = done_cnt + errp_cnt + errt_cnt; d0 = done_cnt;
        send_req(15'h0600, 4, 1, 0, 21, 1, ind);
        send_req(15'h0680, 3, 0, 1, 33, 1, ind2);
        check(ind2 == 1'b1, "R9", "accepted in done cycle", ind2, 1);
        wait_events(base + 2);
        check(done_cnt == d0 + 2, "R9", "both transactions done", done_cnt, d0 + 2);
        check(exp_q.size() == 0, "R2", "writes outstanding", exp_q.size(), 0);

        // R8: memory never ready
        stuck = 1;
        base = done_cnt + errp_cnt + errt_cnt; d0 = done_cnt; wt0 = errt_cnt;
        send_req(15'h0700, 2, 0, 0, 5, 1, ind);
        wait_events(base + 1);
        check(errt_cnt == wt0 + 1, "R8", "timeout flagged", errt_cnt, wt0 + 1);
        check(done_cnt == d0, "R8", "no done on timeout", done_cnt, d0);
        @(negedge clk);
        check(req_ready == 1'b1, "R8", "idle after timeout", req_ready, 1);
        stuck = 0;
        repeat (BUSY + 50) @(negedge clk);
        finish_run();
    end
endmodule